// File: doc/BRIEF.md
# IDE DMA Sector Progress Tracker

This block runs the sequencing side of a bus-master IDE DMA transfer. A descriptor-driven DMA channel hands it one descriptor at a time, each an address and a byte length. The block sends the whole length as one chunk request to a storage request port. When the storage side reports completion, the block updates the drive's position. It then raises completion status and the interrupt where due, and reports the end of the DMA back to the channel as a one-cycle done pulse that carries an error bit.

The block keeps two progress models, and a configuration load selects one of them. The disk model counts in 512-byte sectors and rounds every chunk up to whole sectors. The packet model, for an optical packet device, counts 2048-byte blocks. It keeps a byte index inside the current block and a signed count of the packet bytes still outstanding. From the block address and the byte index it derives the media offset in 512-byte units. The descriptor input and the request output use valid/ready. A descriptor is taken only while `desc_ready` is high, which is only when the block is idle and not being loaded. A request is held unchanged until `req_ready` is seen high. Completion, configuration and status are plain pins.

Top module: `ide_dma_progress`

## Requirements
- R1: `desc_ready` is high only in the idle state when `cfg_load` is low, and `req_valid` is never high at the same time. A descriptor of length zero issues no request and gives `done` with `done_err`=0 and `err_code`=0.
- R2: Disk mode: a successful chunk of N bytes advances `sector` by (N+511)>>9 and lowers `remain_sectors` by the same amount (modulo their widths).
- R3: Disk mode: whenever an accounting step leaves `remain_sectors` at zero, `status` becomes 0x50 and `irq` pulses for one cycle. Each descriptor has an accounting step at its start with size zero and another after a successful chunk.
- R4: Packet mode: a successful chunk of N bytes lowers `remain_bytes` by N, adds N to `byte_index`, advances `lba` by the sum >>11, and keeps only the low 11 bits of the sum in `byte_index`.
- R5: Packet mode: whenever an accounting step leaves `remain_bytes` at zero or below (signed), `status` becomes 0x50 and both `cmd_ok` and `irq` pulse for one cycle.
- R6: A request carries the descriptor address and length. Its `req_offset` is `sector` in disk mode and `lba`*4 + (`byte_index`>>9) in packet mode. `req_write` equals the loaded direction in disk mode and is 0 in packet mode. Issuing a disk request resets `byte_index` to 0.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_len`, `req_offset` and `req_write` stay unchanged.
- R8: A completion with `cmp_err`=0 runs the accounting step and then gives `done` with `done_err`=0.
- R9: A completion with `cmp_err`=1 gives `done` with `done_err`=1 and no accounting. `err_code` is 1 in disk mode and 2 in packet mode, `status` becomes 0x51, and `irq` pulses.
- R10: Packet mode with `media_absent` high when the request would be issued gives no request, `done` with `done_err`=1, `err_code`=3, `status` 0x51 and an `irq` pulse.
- R11: After reset `status` is 0x00 and `done`, `req_valid`, `irq` are low. A `cfg_load` in idle loads the mode, direction and all position values, sets `status` to 0x80 and clears `err_code`.
- R12: `done` is a single-cycle pulse. `cmp_valid` is ignored unless a request has been accepted and its completion is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load drive configuration (taken in idle) |
| cfg_packet | input | 1 | 1 = packet optical device, 0 = disk |
| cfg_write | input | 1 | Disk direction: 1 = memory to media |
| cfg_sector | input | SECT_W | Starting disk sector |
| cfg_count | input | CNT_W | Disk sectors remaining |
| cfg_lba | input | LBA_W | Starting packet block address |
| cfg_index | input | 11 | Byte index inside the 2048-byte block |
| cfg_remain | input | PKT_W | Signed packet bytes remaining |
| media_absent | input | 1 | Packet request cannot be issued |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted this cycle if valid |
| desc_addr | input | ADDR_W | Descriptor memory address |
| desc_len | input | LEN_W | Descriptor byte length |
| req_valid | output | 1 | Storage request pending |
| req_ready | input | 1 | Storage side accepts request |
| req_write | output | 1 | 1 = write memory to media |
| req_addr | output | ADDR_W | Memory address of the chunk |
| req_len | output | LEN_W | Chunk byte length |
| req_offset | output | LBA_W+2 | Media offset in 512-byte units |
| cmp_valid | input | 1 | Chunk completion strobe |
| cmp_err | input | 1 | Chunk failed |
| done | output | 1 | End-of-DMA pulse |
| done_err | output | 1 | Error flag with `done` |
| err_code | output | 2 | 0 none, 1 disk DMA, 2 packet I/O, 3 no medium |
| irq | output | 1 | Device interrupt pulse |
| cmd_ok | output | 1 | Packet command success pulse |
| status | output | 8 | Device status byte |
| sector | output | SECT_W | Current disk sector |
| remain_sectors | output | CNT_W | Disk sectors remaining |
| lba | output | LBA_W | Current packet block address |
| byte_index | output | 11 | Byte index inside the block |
| remain_bytes | output | PKT_W | Signed packet bytes remaining |

## Verification
The hardest situations to reach are the carry paths of the packet model. One needs a chunk that pushes the byte index across a 2048-byte boundary. The other needs a chunk that drives the signed remainder to exactly zero or below it, both on the same descriptor. The stimulus gets there by loading the index and remainder directly through the configuration pins. It loads them close to those boundaries, both in directed cases and in random draws that favour lengths near multiples of 512 and 2048. The no-medium fault is reached only on the launch cycle, so random runs hold `media_absent` for whole descriptors in packet mode.

// File: rtl/idp_pkg.sv
package idp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACCT, ST_LAUNCH, ST_ISSUE, ST_WAIT
  } phase_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_DMA     = 2'd1,
    ERR_IO      = 2'd2,
    ERR_NOMEDIA = 2'd3
  } fault_e;

  localparam logic [7:0] STAT_BUSY  = 8'h80;
  localparam logic [7:0] STAT_READY = 8'h50;  // ready + seek complete
  localparam logic [7:0] STAT_FAULT = 8'h51;  // ready + error

  localparam int SUB_W      = 11;  // bits of byte index inside a 2048-byte block
  localparam int SECT_SHIFT = 9;   // 512-byte units
endpackage

// File: rtl/idp_disk_acct.sv
module idp_disk_acct
  import idp_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int SECT_W = 28,
  parameter int CNT_W  = 16
) (
  input  logic [LEN_W-1:0]  size_i,
  input  logic [SECT_W-1:0] sector_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [SECT_W-1:0] sector_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              drained_o
);
  localparam int RW = LEN_W + 1;

  logic [RW-1:0] rounded;
  logic [RW-1:0] used;

  // round the chunk up to whole sectors
  always_comb begin
    rounded   = RW'(size_i) + RW'((1 << SECT_SHIFT) - 1);
    used      = rounded >> SECT_SHIFT;
    sector_o  = sector_i + SECT_W'(used);
    count_o   = count_i - CNT_W'(used);
    drained_o = (count_o == '0);
  end
endmodule

// File: rtl/idp_pkt_acct.sv
module idp_pkt_acct
  import idp_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LBA_W = 32,
  parameter int PKT_W = 32
) (
  input  logic [LEN_W-1:0]        size_i,
  input  logic [LBA_W-1:0]        lba_i,
  input  logic [SUB_W-1:0]        idx_i,
  input  logic signed [PKT_W-1:0] rem_i,
  output logic [LBA_W-1:0]        lba_o,
  output logic [SUB_W-1:0]        idx_o,
  output logic signed [PKT_W-1:0] rem_o,
  output logic                    finished_o,
  output logic [LBA_W+1:0]        offset_o
);
  localparam int IW = LEN_W + 1;

  logic [IW-1:0] idx_sum;

  always_comb begin
    idx_sum    = IW'(idx_i) + IW'(size_i);
    lba_o      = lba_i + LBA_W'(idx_sum >> SUB_W);
    idx_o      = idx_sum[SUB_W-1:0];
    rem_o      = rem_i - $signed(PKT_W'(size_i));
    finished_o = rem_o[PKT_W-1] | (rem_o == '0);
    // media position in 512-byte units: four per block plus sub-block part
    offset_o   = {lba_i, 2'b00} + (LBA_W + 2)'(idx_i >> SECT_SHIFT);
  end
endmodule

// File: rtl/ide_dma_progress.sv
module ide_dma_progress
  import idp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int SECT_W = 28,
  parameter int CNT_W  = 16,
  parameter int LBA_W  = 32,
  parameter int PKT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic                    cfg_packet,
  input  logic                    cfg_write,
  input  logic [SECT_W-1:0]       cfg_sector,
  input  logic [CNT_W-1:0]        cfg_count,
  input  logic [LBA_W-1:0]        cfg_lba,
  input  logic [10:0]             cfg_index,
  input  logic signed [PKT_W-1:0] cfg_remain,
  input  logic                    media_absent,
  input  logic                    desc_valid,
  output logic                    desc_ready,
  input  logic [ADDR_W-1:0]       desc_addr,
  input  logic [LEN_W-1:0]        desc_len,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic                    req_write,
  output logic [ADDR_W-1:0]       req_addr,
  output logic [LEN_W-1:0]        req_len,
  output logic [LBA_W+1:0]        req_offset,
  input  logic                    cmp_valid,
  input  logic                    cmp_err,
  output logic                    done,
  output logic                    done_err,
  output logic [1:0]              err_code,
  output logic                    irq,
  output logic                    cmd_ok,
  output logic [7:0]              status,
  output logic [SECT_W-1:0]       sector,
  output logic [CNT_W-1:0]        remain_sectors,
  output logic [LBA_W-1:0]        lba,
  output logic [10:0]             byte_index,
  output logic signed [PKT_W-1:0] remain_bytes
);
  localparam int OFF_W = LBA_W + 2;

  phase_e                  st_q;
  logic                    pkt_q, wr_q;
  logic [SECT_W-1:0]       sector_q;
  logic [CNT_W-1:0]        nsect_q;
  logic [LBA_W-1:0]        lba_q;
  logic [SUB_W-1:0]        idx_q;
  logic signed [PKT_W-1:0] rem_q;
  logic [LEN_W-1:0]        bufsz_q, cur_len_q, req_len_q;
  logic [ADDR_W-1:0]       cur_addr_q, req_addr_q;
  logic [OFF_W-1:0]        req_off_q;
  logic                    req_wr_q;
  logic                    done_q, done_err_q, irq_q, cmd_ok_q;
  fault_e                  fault_q;
  logic [7:0]              status_q;

  // next-position values from the two progress models
  logic [SECT_W-1:0]       d_sector_nx;
  logic [CNT_W-1:0]        d_count_nx;
  logic                    d_drained;
  logic [LBA_W-1:0]        p_lba_nx;
  logic [SUB_W-1:0]        p_idx_nx;
  logic signed [PKT_W-1:0] p_rem_nx;
  logic                    p_finished;
  logic [OFF_W-1:0]        p_offset;

  idp_disk_acct #(.LEN_W(LEN_W), .SECT_W(SECT_W), .CNT_W(CNT_W)) u_disk (
    .size_i   (bufsz_q),
    .sector_i (sector_q),
    .count_i  (nsect_q),
    .sector_o (d_sector_nx),
    .count_o  (d_count_nx),
    .drained_o(d_drained)
  );

  idp_pkt_acct #(.LEN_W(LEN_W), .LBA_W(LBA_W), .PKT_W(PKT_W)) u_pkt (
    .size_i    (bufsz_q),
    .lba_i     (lba_q),
    .idx_i     (idx_q),
    .rem_i     (rem_q),
    .lba_o     (p_lba_nx),
    .idx_o     (p_idx_nx),
    .rem_o     (p_rem_nx),
    .finished_o(p_finished),
    .offset_o  (p_offset)
  );

  assign desc_ready = (st_q == ST_IDLE) && !cfg_load;
  assign req_valid  = (st_q == ST_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      pkt_q      <= 1'b0;
      wr_q       <= 1'b0;
      sector_q   <= '0;
      nsect_q    <= '0;
      lba_q      <= '0;
      idx_q      <= '0;
      rem_q      <= '0;
      bufsz_q    <= '0;
      cur_len_q  <= '0;
      cur_addr_q <= '0;
      req_len_q  <= '0;
      req_addr_q <= '0;
      req_off_q  <= '0;
      req_wr_q   <= 1'b0;
      done_q     <= 1'b0;
      done_err_q <= 1'b0;
      irq_q      <= 1'b0;
      cmd_ok_q   <= 1'b0;
      fault_q    <= ERR_NONE;
      status_q   <= 8'h00;
    end else begin
      done_q     <= 1'b0;
      done_err_q <= 1'b0;
      irq_q      <= 1'b0;
      cmd_ok_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (cfg_load) begin
            pkt_q    <= cfg_packet;
            wr_q     <= cfg_write;
            sector_q <= cfg_sector;
            nsect_q  <= cfg_count;
            lba_q    <= cfg_lba;
            idx_q    <= cfg_index;
            rem_q    <= cfg_remain;
            status_q <= STAT_BUSY;
            fault_q  <= ERR_NONE;
          end else if (desc_valid) begin
            cur_addr_q <= desc_addr;
            cur_len_q  <= desc_len;
            bufsz_q    <= '0;  // a new transfer starts with nothing buffered
            st_q       <= ST_ACCT;
          end
        end
        ST_ACCT: begin
          if (pkt_q) begin
            lba_q <= p_lba_nx;
            idx_q <= p_idx_nx;
            rem_q <= p_rem_nx;
            if (p_finished) begin
              cmd_ok_q <= 1'b1;
              irq_q    <= 1'b1;
              status_q <= STAT_READY;
            end
          end else begin
            sector_q <= d_sector_nx;
            nsect_q  <= d_count_nx;
            if (d_drained) begin
              irq_q    <= 1'b1;
              status_q <= STAT_READY;
            end
          end
          bufsz_q <= '0;
          if (cur_len_q == '0) begin
            done_q  <= 1'b1;
            fault_q <= ERR_NONE;
            st_q    <= ST_IDLE;
          end else begin
            st_q <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          if (pkt_q && media_absent) begin
            done_q     <= 1'b1;
            done_err_q <= 1'b1;
            fault_q    <= ERR_NOMEDIA;
            status_q   <= STAT_FAULT;
            irq_q      <= 1'b1;
            st_q       <= ST_IDLE;
          end else begin
            req_addr_q <= cur_addr_q;
            req_len_q  <= cur_len_q;
            req_off_q  <= pkt_q ? p_offset : OFF_W'(sector_q);
            req_wr_q   <= !pkt_q && wr_q;
            bufsz_q    <= cur_len_q;
            cur_addr_q <= cur_addr_q + ADDR_W'(cur_len_q);
            cur_len_q  <= '0;
            if (!pkt_q) idx_q <= '0;
            st_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cmp_valid) begin
            if (cmp_err) begin
              done_q     <= 1'b1;
              done_err_q <= 1'b1;
              fault_q    <= pkt_q ? ERR_IO : ERR_DMA;
              status_q   <= STAT_FAULT;
              irq_q      <= 1'b1;
              st_q       <= ST_IDLE;
            end else begin
              st_q <= ST_ACCT;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_write      = req_wr_q;
  assign req_addr       = req_addr_q;
  assign req_len        = req_len_q;
  assign req_offset     = req_off_q;
  assign done           = done_q;
  assign done_err       = done_err_q;
  assign err_code       = fault_q;
  assign irq            = irq_q;
  assign cmd_ok         = cmd_ok_q;
  assign status         = status_q;
  assign sector         = sector_q;
  assign remain_sectors = nsect_q;
  assign lba            = lba_q;
  assign byte_index     = idx_q;
  assign remain_bytes   = rem_q;

  // ---------------- assertions ----------------
  logic [CNT_W-1:0] disk_total;
  logic [PKT_W-1:0] pkt_total;
  assign disk_total = CNT_W'(sector_q) + nsect_q;
  assign pkt_total  = PKT_W'({lba_q, idx_q}) + PKT_W'(rem_q);

  assert_ready_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_ready && req_valid));

  // sectors consumed by the disk model equal sectors advanced
  assert_disk_balance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACCT && !pkt_q) |=> $stable(disk_total));

  // bytes consumed by the packet model equal bytes advanced
  assert_pkt_balance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACCT && pkt_q) |=> $stable(pkt_total));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)
                                   && $stable(req_offset) && $stable(req_write)));

  assert_err_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

  assert_no_media_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LAUNCH && pkt_q && media_absent) |=> (!req_valid && done && err_code == 2'd3));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/test_ide_dma_progress.sv
`timescale 1ns/1ps
module test_ide_dma_progress;
  logic clk = 0, rst_n = 0;
  logic cfg_load = 0, cfg_packet = 0, cfg_write = 0;
  logic [27:0] cfg_sector = 0;
  logic [15:0] cfg_count = 0;
  logic [31:0] cfg_lba = 0;
  logic [10:0] cfg_index = 0;
  logic signed [31:0] cfg_remain = 0;
  logic media_absent = 0, desc_valid = 0, desc_ready;
  logic [31:0] desc_addr = 0;
  logic [15:0] desc_len = 0;
  logic req_valid, req_ready = 0, req_write;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic [33:0] req_offset;
  logic cmp_valid = 0, cmp_err = 0;
  logic done, done_err, irq, cmd_ok;
  logic [1:0] err_code;
  logic [7:0] status;
  logic [27:0] sector;
  logic [15:0] remain_sectors;
  logic [31:0] lba;
  logic [10:0] byte_index;
  logic signed [31:0] remain_bytes;

  ide_dma_progress i_ide_dma_progress (.*);

  always #5 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  int irq_seen = 0, ok_seen = 0, req_seen = 0;
  always @(posedge clk) begin
    if (irq) irq_seen++;
    if (cmd_ok) ok_seen++;
    if (req_valid && req_ready) req_seen++;
  end

  // bench model of the drive position
  bit m_pkt, m_wr;
  logic [27:0] m_sect;
  logic [15:0] m_nsect;
  logic [31:0] m_lba;
  logic [10:0] m_idx;
  logic signed [31:0] m_rem;
  logic [7:0] m_stat;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned sect_used(input int unsigned len);
    return (len + 511) >> 9;
  endfunction

  function automatic longint pkt_off(input logic [31:0] l, input logic [10:0] i);
    return longint'(l) * 4 + longint'(i >> 9);
  endfunction

  // accounting step in the model; returns number of irq/cmd_ok pulses it makes
  task automatic model_acct(input int unsigned len, inout int ie, inout int oe);
    if (m_pkt) begin
      int unsigned s;
      m_rem = m_rem - $signed(len);
      s = int'(m_idx) + len;
      m_lba = m_lba + (s >> 11);
      m_idx = 11'(s);
      if (m_rem <= 0) begin ie++; oe++; m_stat = 8'h50; end
    end else begin
      m_sect  = m_sect + 28'(sect_used(len));
      m_nsect = m_nsect - 16'(sect_used(len));
      if (m_nsect == 0) begin ie++; m_stat = 8'h50; end
    end
  endtask

  task automatic check_pos(input string tag);
    chk(sector == m_sect, {tag, " sector"}, sector, m_sect);
    chk(remain_sectors == m_nsect, {tag, " remain_sectors"}, remain_sectors, m_nsect);
    chk(lba == m_lba, {tag, " lba"}, lba, m_lba);
    chk(byte_index == m_idx, {tag, " byte_index"}, byte_index, m_idx);
    chk(remain_bytes == m_rem, {tag, " remain_bytes"}, remain_bytes, m_rem);
  endtask

  task automatic do_cfg(input bit pk, input bit wr, input logic [27:0] s, input logic [15:0] c,
                        input logic [31:0] l, input logic [10:0] ix, input logic signed [31:0] r);
    @(negedge clk);
    cfg_packet = pk; cfg_write = wr; cfg_sector = s; cfg_count = c;
    cfg_lba = l; cfg_index = ix; cfg_remain = r; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
    m_pkt = pk; m_wr = wr; m_sect = s; m_nsect = c; m_lba = l; m_idx = ix; m_rem = r;
    m_stat = 8'h80;
    chk(status == 8'h80, "R11 status after load", status, 8'h80);
    chk(err_code == 0, "R11 err_code after load", err_code, 0);
    check_pos("R11 load");
  endtask

  task automatic run_desc(input logic [31:0] a, input logic [15:0] len, input bit err,
                          input bit absent, input int dly);
    int ie = 0, oe = 0, re = 0, cyc = 0;
    int irq0 = irq_seen, ok0 = ok_seen, req0 = req_seen;
    bit got = 0, exp_err = 0;
    int exp_code = 0;
    longint e_off = 0;
    bit e_wr = 0;
    model_acct(0, ie, oe);
    if (len != 0) begin
      if (m_pkt && absent) begin
        exp_err = 1; exp_code = 3; ie++; m_stat = 8'h51;
      end else begin
        re = 1;
        e_off = m_pkt ? pkt_off(m_lba, m_idx) : longint'(m_sect);
        e_wr  = !m_pkt && m_wr;
        if (!m_pkt) m_idx = 0;
        if (err) begin
          exp_err = 1; exp_code = m_pkt ? 2 : 1; ie++; m_stat = 8'h51;
        end else model_acct(len, ie, oe);
      end
    end
    @(negedge clk);
    chk(desc_ready == 1, "R1 desc_ready in idle", desc_ready, 1);
    desc_valid = 1; desc_addr = a; desc_len = len; media_absent = absent;
    @(negedge clk);
    desc_valid = 0;
    chk(desc_ready == 0, "R1 desc_ready busy", desc_ready, 0);
    while (!got && cyc < 60) begin
      @(negedge clk); cyc++;
      if (done) got = 1;
      else if (req_valid) begin
        chk(req_addr == a, "R6 req_addr", req_addr, a);
        chk(req_len == len, "R6 req_len", req_len, len);
        chk(req_offset == 34'(e_off), "R6 req_offset", req_offset, e_off);
        chk(req_write == e_wr, "R6 req_write", req_write, e_wr);
        chk(m_pkt || byte_index == 0, "R6 disk index reset", byte_index, 0);
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          chk(req_valid && req_offset == 34'(e_off) && req_len == len,
              "R7 request held", req_offset, e_off);
        end
        req_ready = 1;
        @(negedge clk);
        req_ready = 0;
        repeat (2) @(negedge clk);
        cmp_valid = 1; cmp_err = err;
        @(negedge clk);
        cmp_valid = 0; cmp_err = 0;
        got = done;
      end
    end
    media_absent = 0;
    chk(got, "R8 done seen", got, 1);
    chk(done_err == exp_err, exp_err ? "R9 done_err set" : "R8 done_err clear", done_err, exp_err);
    chk(err_code == exp_code, exp_code == 3 ? "R10 err_code" : "R9 err_code", err_code, exp_code);
    @(negedge clk);
    chk(done == 0, "R12 done single cycle", done, 0);
    chk(req_seen - req0 == re, len == 0 ? "R1 no request for zero length" : "R10 request count",
        req_seen - req0, re);
    chk(irq_seen - irq0 == ie, m_pkt ? "R5 irq pulses" : "R3 irq pulses", irq_seen - irq0, ie);
    chk(ok_seen - ok0 == oe, "R5 cmd_ok pulses", ok_seen - ok0, oe);
    chk(status == m_stat, "R3 status", status, m_stat);
    check_pos(m_pkt ? "R4" : "R2");
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int seed = 32'h1DE5;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(status == 0 && !done && !req_valid && !irq, "R11 reset state", status, 0);
    rst_n = 1;
    @(negedge clk);
    chk(desc_ready == 1, "R1 ready after reset", desc_ready, 1);

    // disk round-up: 1, 512, 513 bytes (R2), draining to zero (R3), write flag (R6)
    do_cfg(0, 1, 28'd100, 16'd4, 0, 11'd77, 0);
    run_desc(32'h1000, 16'd1, 0, 0, 0);
    run_desc(32'h2000, 16'd512, 0, 0, 2);
    run_desc(32'h3000, 16'd513, 0, 0, 1);
    run_desc(32'h4000, 16'd0, 0, 0, 0);
    // disk error (R9)
    do_cfg(0, 0, 28'd7, 16'd9, 0, 0, 0);
    run_desc(32'h5000, 16'd1024, 1, 0, 0);

    // completion strobe while idle is ignored (R12)
    @(negedge clk); cmp_valid = 1; cmp_err = 1;
    @(negedge clk); cmp_valid = 0; cmp_err = 0;
    @(negedge clk);
    chk(!done && status == 8'h51 && sector == 28'd7, "R12 cmp ignored in idle", status, 8'h51);

    // packet: index crosses block boundary (R4), offset (R6), remainder to zero (R5)
    do_cfg(1, 1, 0, 0, 32'd10, 11'd2000, 32'sd100);
    run_desc(32'h6000, 16'd100, 0, 0, 1);
    do_cfg(1, 0, 0, 0, 32'd3, 11'd1536, 32'sd5000);
    run_desc(32'h7000, 16'd4096, 0, 0, 0);
    run_desc(32'h8000, 16'd512, 1, 0, 0);
    run_desc(32'h9000, 16'd512, 0, 1, 0);
    run_desc(32'hA000, 16'd0, 0, 1, 0);

    // random
    for (int t = 0; t < 60; t++) begin
      bit pk = $urandom_range(0, 1);
      do_cfg(pk, 1'($urandom), 28'($urandom), 16'($urandom_range(0, 24)),
             $urandom_range(0, 100000), 11'($urandom), $signed($urandom_range(0, 20000)) - 32'sd1000);
      for (int d = 0; d < 3; d++) begin
        logic [15:0] l;
        case ($urandom_range(0, 3))
          0: l = 0;
          1: l = 16'($urandom_range(1, 3) * 512);
          2: l = 16'($urandom_range(1, 4) * 2048 + $urandom_range(0, 2) - 1);
          default: l = 16'($urandom_range(1, 9000));
        endcase
        run_desc($urandom, l, $urandom_range(0, 7) == 0, pk && $urandom_range(0, 5) == 0,
                 $urandom_range(0, 3));
      end
    end
    report();
  end
endmodule